// File: doc/BRIEF.md
# Transmit Packet Framer

The framer turns a stream of payload bytes into a complete transmit frame for a short-range low-rate radio. The host presents the payload length on `len_i` and pulses `start_i`. The block then emits a byte stream on a valid/ready output:

- four preamble bytes of 0x00;
- the delimiter 0xA7;
- a length byte;
- the payload bytes, passed through from the input stream;
- a 16-bit check sequence that it accumulates over the payload as the bytes go by.

Both stream interfaces follow valid/ready rules. A byte moves when valid and ready are high at the same clock edge. Once the framer raises `out_valid_o`, it keeps `out_data_o` unchanged until the byte is accepted. During the payload, the output stream is a direct pass-through of the input stream:

- `out_valid_o` follows `in_valid_i`;
- `in_ready_o` follows `out_ready_i`.

The upstream source must therefore hold its byte while it waits. A stall at the output reaches the payload source in the same cycle. `busy_o`, `done_o` and `err_o` are plain status pins.

Top module: `pkt_framer`

## Requirements
- R1: When `start_i` is high in a cycle with `busy_o` low and `len_i` ≤ 125, `busy_o` is high from the next edge on, and the first four bytes delivered are 0x00.
- R2: The fifth byte delivered is the delimiter 0xA7.
- R3: The sixth byte delivered is the length field, equal to `len_i` + 2 (payload plus the two check bytes).
- R4: Next come exactly `len_i` payload bytes, in the order they arrive on the input stream. `in_ready_o` is high only while payload is due and only when `out_ready_i` is high.
- R5: The last two bytes are the CRC-16 of the payload bytes only, low byte first. The CRC uses polynomial x^16+x^12+x^5+1, initial value 0 and least significant bit first, with no final inversion. For the payload "123456789" the two bytes are 0x89 then 0x21.
- R6: A start with `len_i` > 125 is rejected: `err_o` is high for exactly the one cycle after that edge, `busy_o` stays low and no byte is offered.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the next cycle still has `out_valid_o` high and the same `out_data_o`.
- R8: `done_o` is a one-cycle pulse in the cycle after the last check byte is accepted. In that same cycle `busy_o` and `out_valid_o` are low.
- R9: A `start_i` pulse while `busy_o` is high has no effect: no `err_o`, and the running frame is unchanged.
- R10: A length of 0 gives a frame of preamble, delimiter, length byte 0x02 and check bytes 0x00 0x00.
- R11: During reset and right after it, `out_valid_o`, `in_ready_o`, `busy_o`, `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a frame |
| len_i | input | 8 | Payload length in bytes, sampled with `start_i` |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle pulse after the last byte is accepted |
| err_o | output | 1 | One-cycle pulse when a start is rejected for length |
| in_valid_i | input | 1 | Payload byte available |
| in_data_i | input | 8 | Payload byte |
| in_ready_o | output | 1 | Framer takes the payload byte this cycle |
| out_valid_o | output | 1 | Frame byte available |
| out_data_o | output | 8 | Frame byte |
| out_ready_i | input | 1 | Downstream takes the frame byte this cycle |

## Verification
The outputs have different latencies:

- **`busy_o` and the first preamble byte:** appear one edge after the start.
- **`err_o`:** appears one edge after a rejected start and is gone one edge later.
- **`done_o`:** appears one edge after the edge that accepts the second check byte.
- **Payload pass-through:** combinational within the cycle.

The bench drives inputs at the falling edge and samples one nanosecond later. Each handshake is therefore judged on the values that the next rising edge will see. Each status pin is checked in the sample that follows the edge where its result is due, and again one cycle later for pulses. Frame bytes are collected in order at each handshake and compared field by field against values the bench computes from the length and the payload.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
  localparam int BYTE_W = 8;
  localparam int FCS_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_LEN,
    ST_PAY,
    ST_FCS_LO,
    ST_FCS_HI
  } frm_state_e;

  // One byte through a reflected CRC register, bit 0 of the byte first.
  function automatic logic [FCS_W-1:0] crc_byte(input logic [FCS_W-1:0] crc,
                                                input logic [BYTE_W-1:0] data,
                                                input logic [FCS_W-1:0] poly_ref);
    logic [FCS_W-1:0] acc;
    acc = crc;
    for (int b = 0; b < BYTE_W; b++) begin
      if (acc[0] ^ data[b]) acc = (acc >> 1) ^ poly_ref;
      else                  acc = acc >> 1;
    end
    return acc;
  endfunction
endpackage

// File: rtl/pkt_framer_crc.sv
module pkt_framer_crc
  import pkt_framer_pkg::*;
#(
  parameter logic [FCS_W-1:0] POLY_REF = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [FCS_W-1:0]  crc_o
);
  logic [FCS_W-1:0] crc_q;
  logic [FCS_W-1:0] crc_next;

  always_comb crc_next = crc_byte(crc_q, data_i, POLY_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= '0;
    else if (clear_i) crc_q <= '0;
    else if (step_i)  crc_q <= crc_next;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/pkt_framer_ctrl.sv
module pkt_framer_ctrl
  import pkt_framer_pkg::*;
#(
  parameter int PRE_LEN     = 4,
  parameter int MAX_PAYLOAD = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] len_i,
  input  logic              in_valid_i,
  input  logic              out_ready_i,
  output frm_state_e        state_o,
  output logic [BYTE_W-1:0] len_o,
  output logic              out_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int CNT_W = $clog2(((PRE_LEN > MAX_PAYLOAD) ? PRE_LEN : MAX_PAYLOAD) + 1);

  frm_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] len_q;
  logic              done_q, err_q;
  logic              accept;

  assign out_valid_o = (state_q == ST_PAY) ? in_valid_i : (state_q != ST_IDLE);
  assign accept      = out_valid_o & out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (int'(len_i) > MAX_PAYLOAD) err_q <= 1'b1;
          else begin
            state_q <= ST_PRE;
            len_q   <= len_i;
            cnt_q   <= '0;
          end
        end
        ST_PRE: if (accept) begin
          if (int'(cnt_q) == PRE_LEN - 1) begin
            state_q <= ST_SFD;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_SFD: if (accept) state_q <= ST_LEN;
        ST_LEN: if (accept) state_q <= (len_q == '0) ? ST_FCS_LO : ST_PAY;
        ST_PAY: if (accept) begin
          if (int'(cnt_q) == int'(len_q) - 1) begin
            state_q <= ST_FCS_LO;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_FCS_LO: if (accept) state_q <= ST_FCS_HI;
        ST_FCS_HI: if (accept) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign len_o   = len_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import pkt_framer_pkg::*;
#(
  parameter int                PRE_LEN     = 4,
  parameter int                MAX_PAYLOAD = 125,
  parameter logic [BYTE_W-1:0] PRE_BYTE    = 8'h00,
  parameter logic [BYTE_W-1:0] SFD_BYTE    = 8'hA7,
  parameter logic [FCS_W-1:0]  POLY_REF    = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  input  logic              out_ready_i
);
  localparam logic [BYTE_W-1:0] FCS_BYTES = BYTE_W'(FCS_W / BYTE_W);

  frm_state_e        state;
  logic [BYTE_W-1:0] len_q;
  logic [FCS_W-1:0]  crc;
  logic              pay_take;

  pkt_framer_ctrl #(
    .PRE_LEN    (PRE_LEN),
    .MAX_PAYLOAD(MAX_PAYLOAD)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .len_i      (len_i),
    .in_valid_i (in_valid_i),
    .out_ready_i(out_ready_i),
    .state_o    (state),
    .len_o      (len_q),
    .out_valid_o(out_valid_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  assign in_ready_o = (state == ST_PAY) & out_ready_i;
  assign pay_take   = in_ready_o & in_valid_i;

  pkt_framer_crc #(
    .POLY_REF(POLY_REF)
  ) crc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(state == ST_IDLE),
    .step_i (pay_take),
    .data_i (in_data_i),
    .crc_o  (crc)
  );

  always_comb begin
    unique case (state)
      ST_PRE:    out_data_o = PRE_BYTE;
      ST_SFD:    out_data_o = SFD_BYTE;
      ST_LEN:    out_data_o = len_q + FCS_BYTES;
      ST_PAY:    out_data_o = in_data_i;
      ST_FCS_LO: out_data_o = crc[BYTE_W-1:0];
      ST_FCS_HI: out_data_o = crc[FCS_W-1:BYTE_W];
      default:   out_data_o = '0;
    endcase
  end
endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk #(
  parameter int MAX_PAYLOAD = 125
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [7:0] len_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic       out_valid_o,
  input logic [7:0] out_data_o,
  input logic       out_ready_i
);
  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i && (!in_ready_o || in_valid_i) |=> out_valid_o && $stable(out_data_o)); // R7
  AST_REJECT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i && (int'(len_i) > MAX_PAYLOAD) |=> err_o && !busy_o && !out_valid_o); // R6
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o || $past(start_i)); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> !err_o); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !out_valid_o); // R8
  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o |-> out_ready_i && busy_o); // R4
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i && (int'(len_i) <= MAX_PAYLOAD) |=> busy_o && out_valid_o && (out_data_o == 8'h00)); // R1
endmodule

bind pkt_framer pkt_framer_chk #(.MAX_PAYLOAD(MAX_PAYLOAD)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .len_i      (len_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .out_ready_i(out_ready_i)
);

// File: tb/pkt_framer_tb.sv
module pkt_framer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] len_i = '0;
  logic       busy_o, done_o, err_o;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_ready_o;
  logic       out_valid_o;
  logic [7:0] out_data_o;
  logic       out_ready_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [7:0] pl  [0:127];
  logic [7:0] got [0:140];

  always #2.5 clk = ~clk;

  pkt_framer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] r = 16'h0000;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb = r[0] ^ pl[i][b];
        r = {1'b0, r[15:1]};
        if (fb) r = r ^ 16'h8408;
      end
    end
    return r;
  endfunction

  // One frame: stall = every Nth cycle ready drops (0 = none),
  // gaps = upstream idles some cycles, mid = extra start while busy.
  task automatic run_frame(input int len, input int stall, input bit gaps,
                           input bit mid, input string tag);
    int n = 0, pidx = 0, cyc = 0, hold_bad = 0, bad;
    bit prev_stall = 0, err_seen = 0;
    logic [7:0] prev_data = '0;
    logic [15:0] fcs;
    int total = len + 8;
    @(negedge clk);
    start_i = 1'b1; len_i = 8'(len);
    @(negedge clk);
    start_i = 1'b0;
    #1 check(busy_o === 1'b1, {"R1 busy after start ", tag}, busy_o, 1);
    while (n < total && cyc < 3000) begin
      if (cyc > 0) @(negedge clk);
      out_ready_i = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      if (!in_valid_i) in_valid_i = (pidx < len) && !(gaps && (cyc % 3 == 1));
      in_data_i = pl[pidx < 128 ? pidx : 0];
      start_i = mid && (cyc == 8);
      len_i = mid ? 8'd200 : len_i;
      #1;
      if (prev_stall && !(out_valid_o && out_data_o == prev_data)) hold_bad++;
      prev_stall = out_valid_o && !out_ready_i;
      prev_data = out_data_o;
      if (err_o) err_seen = 1;
      if (out_valid_o && out_ready_i) begin
        got[n] = out_data_o;
        n++;
      end
      if (in_valid_i && in_ready_o) begin
        pidx++;
        @(posedge clk);
        #0.5 in_valid_i = 1'b0;
      end
      cyc++;
    end
    start_i = 1'b0;
    check(n == total, {"R4 frame byte count ", tag}, n, total);
    bad = 0;
    for (int i = 0; i < 4; i++) if (got[i] !== 8'h00) bad++;
    check(bad == 0, {"R1 preamble ", tag}, got[0], 0);
    check(got[4] === 8'hA7, {"R2 delimiter ", tag}, got[4], 8'hA7);
    check(got[5] === 8'(len + 2), {"R3 length byte ", tag}, got[5], len + 2);
    bad = 0;
    for (int i = 0; i < len; i++) if (got[6 + i] !== pl[i]) bad++;
    check(bad == 0, {"R4 payload bytes ", tag}, bad, 0);
    fcs = ref_crc(len);
    check({got[total - 1], got[total - 2]} === fcs, {"R5 check bytes ", tag},
          {got[total - 1], got[total - 2]}, fcs);
    if (stall != 0) check(hold_bad == 0, {"R7 hold under stall ", tag}, hold_bad, 0);
    if (mid) check(!err_seen, {"R9 start while busy ignored ", tag}, err_seen, 0);
    @(negedge clk);
    out_ready_i = 1'b0; in_valid_i = 1'b0;
    #1 check(done_o === 1'b1 && busy_o === 1'b0 && out_valid_o === 1'b0,
             {"R8 done pulse ", tag}, {done_o, busy_o, out_valid_o}, 3'b100);
    @(negedge clk);
    #1 check(done_o === 1'b0, {"R8 done one cycle ", tag}, done_o, 0);
  endtask

  task automatic test_reset();
    #1 check({out_valid_o, in_ready_o, busy_o, done_o, err_o} === 5'b0,
             "R11 outputs in reset", {out_valid_o, in_ready_o, busy_o, done_o, err_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check({out_valid_o, in_ready_o, busy_o, done_o, err_o} === 5'b0,
             "R11 outputs after reset", {out_valid_o, in_ready_o, busy_o, done_o, err_o}, 0);
  endtask

  task automatic test_reject(input int len);
    @(negedge clk);
    start_i = 1'b1; len_i = 8'(len);
    @(negedge clk);
    start_i = 1'b0;
    #1 check(err_o === 1'b1 && busy_o === 1'b0 && out_valid_o === 1'b0,
             "R6 oversize rejected", {err_o, busy_o, out_valid_o}, 3'b100);
    @(negedge clk);
    #1 check(err_o === 1'b0 && busy_o === 1'b0, "R6 err one cycle", {err_o, busy_o}, 0);
  endtask

  task automatic test_known_crc();
    string s = "123456789";
    for (int i = 0; i < 9; i++) pl[i] = s[i];
    run_frame(9, 0, 0, 0, "ascii");
    check(got[15] === 8'h89 && got[16] === 8'h21, "R5 known vector",
          {got[16], got[15]}, 16'h2189);
  endtask

  initial begin
    int unsigned wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", wd);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) pl[i] = 8'((i * 37 + 11) ^ (i >> 2));
    test_reset();
    run_frame(5, 0, 0, 0, "plain");
    run_frame(0, 0, 0, 0, "R10 empty");
    run_frame(12, 3, 1, 0, "stall+gaps");
    run_frame(20, 2, 0, 1, "mid-start");
    test_reject(126);
    test_reject(255);
    run_frame(125, 4, 1, 0, "max length");
    test_known_crc();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule